// File: doc/BRIEF.md
# Dual-Channel Conversion Readout Serial Port

This block is the slave side of the serial port of a two-channel converter whose channels sample at the same instant. When the host pulls chip select low, two things happen. The port raises a one-cycle conversion-start strobe so that both channels begin converting. In the same frame, the port shifts out the result words it already holds, which come from the conversion before this one. The result of the conversion started now is therefore read in the next frame.

The port has two output layouts. In the dual-line layout, channel A goes out on line A and channel B goes out on line B in parallel, so the frame needs one serial clock per bit. In the single-line layout, both words go out on line A one after the other, which needs twice as many serial clocks, and line B is driven low. All logic runs on a system clock. Chip select and the serial clock are synchronised and edge-detected inside the block. Result words arrive on a valid/ready stream.

Stream rules for results: a word pair is taken on a clock edge where `res_valid` and `res_ready` are both high. `res_ready` is low while one pair is already waiting. The producer must then hold `res_valid` and both words unchanged. A frame start moves the waiting pair into the shift register, and `res_ready` rises on the next cycle.

Top module: `dual_readout_port`

## Requirements
- R1: Each falling edge of chip select, once detected, produces exactly one `conv_start` pulse one system clock long. No pulse occurs at any other time.
- R2: `sdo_oe` is high from the cycle after `conv_start` until chip select is seen high again. While `sdo_oe` is low, `sdo_a` and `sdo_b` are both 0.
- R3: A frame carries the result pair that was waiting when the frame started. A pair accepted after that start is carried by the next frame.
- R4: In the dual-line layout (`one_wire`=0), bit k of a frame is word bit WORD_W-1-k, so the MSB comes first. A's bit is on `sdo_a` and B's bit is on `sdo_b`. The bit is visible after k detected serial-clock falling edges and does not change while the serial clock stays high.
- R5: In the single-line layout (`one_wire`=1), `sdo_a` carries all of A MSB first and then all of B MSB first, for 2*WORD_W bits. `sdo_b` stays 0 for the whole frame.
- R6: After the last bit of the frame layout has been shifted, further serial-clock falling edges leave the active lines at 0 until chip select rises.
- R7: If chip select rises before all bits have been sent, the frame ends without any error. The next frame restarts from the MSB.
- R8: If no new pair is waiting at frame start, the frame repeats the words of the previous frame.
- R9: `res_ready` is low while a pair is waiting. It stays low until a frame start takes that pair.
- R10: The layout is taken from `one_wire` at frame start. Changing `one_wire` during a frame has no effect on that frame.
- R11: After reset, `sdo_oe`, `sdo_a`, `sdo_b` and `conv_start` are 0, `res_ready` is 1, and the held words are zero. A first frame with no result waiting therefore sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| one_wire | input | 1 | Layout select: 1 = both words on line A, 0 = one line per channel |
| res_valid | input | 1 | Result pair valid |
| res_ready | output | 1 | Port can take a result pair |
| res_a | input | WORD_W | Channel A result word |
| res_b | input | WORD_W | Channel B result word |
| sdo_a | output | 1 | Serial data line A |
| sdo_b | output | 1 | Serial data line B |
| sdo_oe | output | 1 | Drive enable for both data lines; low means high impedance |
| conv_start | output | 1 | One-cycle strobe that starts a conversion on both channels |

## Verification
The bench builds the port with WORD_W = 18, the boosted-resolution width, and SYNC_STAGES = 3. The larger width makes a single-line frame 36 bits long, so the counter saturation point and the seam between the two words lie well away from the small values a narrow build would hit. The deeper synchroniser stretches the delay between a pin edge and its effect. Every sample point in the bench must then tolerate that delay, and the stability property on the data lines is tested against a longer detection window.

// File: rtl/readout_pkg.sv
package readout_pkg;

  typedef enum logic {
    LINK_DUAL   = 1'b0,
    LINK_SINGLE = 1'b1
  } link_mode_e;

  function automatic int unsigned frame_bits(input link_mode_e m, input int unsigned w);
    return (m == LINK_SINGLE) ? 2 * w : w;
  endfunction

endpackage

// File: rtl/rdp_edge_sync.sv
module rdp_edge_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RST_VAL   = 1'b0,
  parameter bit          DETECT_FALL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic edge_p
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= RST_VAL;
        end else if (i == 0) begin
          chain_q[i] <= din;
        end else begin
          chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];

  generate
    if (DETECT_FALL) begin : g_fall
      assign edge_p = prev_q & ~chain_q[STAGES-1];
    end else begin : g_rise
      assign edge_p = ~prev_q & chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rdp_result_stage.sv
module rdp_result_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  input  logic              load,
  output logic [WORD_W-1:0] held_a,
  output logic [WORD_W-1:0] held_b
);

  logic              pend_full_q;
  logic [WORD_W-1:0] pend_a_q, pend_b_q;
  logic              accept;

  assign res_ready = ~pend_full_q;
  assign accept    = res_valid & res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full_q <= 1'b0;
      pend_a_q    <= '0;
      pend_b_q    <= '0;
    end else begin
      pend_full_q <= accept | (pend_full_q & ~load);
      if (accept) begin
        pend_a_q <= res_a;
        pend_b_q <= res_b;
      end
    end
  end

  // Shadow pair: refreshed only at frame start and only from a waiting pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_a <= '0;
      held_b <= '0;
    end else if (load && pend_full_q) begin
      held_a <= pend_a_q;
      held_b <= pend_b_q;
    end
  end

endmodule

// File: rtl/rdp_shift_ctrl.sv
module rdp_shift_ctrl
  import readout_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cs_high,
  input  logic              sclk_fall,
  input  link_mode_e        mode_in,
  input  logic [WORD_W-1:0] held_a,
  input  logic [WORD_W-1:0] held_b,
  output logic              active,
  output link_mode_e        mode_q,
  output logic              sdo_a,
  output logic              sdo_b
);

  localparam int unsigned TOT_W = 2 * WORD_W;
  localparam int unsigned CNT_W = $clog2(TOT_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic [WORD_W-1:0] a_shl, b_shl;
  logic [TOT_W-1:0]  ser_shl;

  assign limit = CNT_W'(frame_bits(mode_q, WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_q <= LINK_DUAL;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      mode_q <= mode_in;
      cnt_q  <= '0;
    end else if (cs_high) begin
      active <= 1'b0;
    end else if (active && sclk_fall && (cnt_q != limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Shifting left by the bit count puts the current bit at the top and
  // runs out to zero once the counter passes the word length.
  assign a_shl   = held_a << cnt_q;
  assign b_shl   = held_b << cnt_q;
  assign ser_shl = {held_a, held_b} << cnt_q;

  always_comb begin
    sdo_a = 1'b0;
    sdo_b = 1'b0;
    if (active) begin
      if (mode_q == LINK_SINGLE) begin
        sdo_a = ser_shl[TOT_W-1];
      end else begin
        sdo_a = a_shl[WORD_W-1];
        sdo_b = b_shl[WORD_W-1];
      end
    end
  end

endmodule

// File: rtl/dual_readout_port.sv
module dual_readout_port
  import readout_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              one_wire,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  output logic              sdo_a,
  output logic              sdo_b,
  output logic              sdo_oe,
  output logic              conv_start
);

  logic              cs_lvl, cs_fall;
  logic              sclk_lvl, sclk_fall;
  logic [WORD_W-1:0] held_a, held_b;
  logic              active;
  link_mode_e        mode_q;
  logic              frame_one;

  rdp_edge_sync #(
    .STAGES     (SYNC_STAGES),
    .RST_VAL    (1'b1),
    .DETECT_FALL(1'b1)
  ) u_cs_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cs_n),
    .level (cs_lvl),
    .edge_p(cs_fall)
  );

  rdp_edge_sync #(
    .STAGES     (SYNC_STAGES),
    .RST_VAL    (1'b0),
    .DETECT_FALL(1'b1)
  ) u_sclk_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sclk),
    .level (sclk_lvl),
    .edge_p(sclk_fall)
  );

  rdp_result_stage #(
    .WORD_W(WORD_W)
  ) u_results (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_a    (res_a),
    .res_b    (res_b),
    .load     (cs_fall),
    .held_a   (held_a),
    .held_b   (held_b)
  );

  rdp_shift_ctrl #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cs_fall),
    .cs_high  (cs_lvl),
    .sclk_fall(sclk_fall),
    .mode_in  (one_wire ? LINK_SINGLE : LINK_DUAL),
    .held_a   (held_a),
    .held_b   (held_b),
    .active   (active),
    .mode_q   (mode_q),
    .sdo_a    (sdo_a),
    .sdo_b    (sdo_b)
  );

  assign frame_one  = active && (mode_q == LINK_SINGLE);
  assign sdo_oe     = active;
  assign conv_start = cs_fall;

endmodule

// File: rtl/dual_readout_port_chk.sv
module dual_readout_port_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic sdo_oe,
  input logic sdo_a,
  input logic sdo_b,
  input logic res_ready,
  input logic frame_one,
  input logic sclk_lvl
);

  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_frame_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> sdo_oe);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> (!sdo_a && !sdo_b));

  assert_bit_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && sclk_lvl && $past(sclk_lvl) && !$past(conv_start))
      |-> ($stable(sdo_a) && $stable(sdo_b)));

  assert_line_b_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_one |-> !sdo_b);

  assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_ready && !conv_start) |=> !res_ready);

endmodule

bind dual_readout_port dual_readout_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_start(conv_start),
  .sdo_oe    (sdo_oe),
  .sdo_a     (sdo_a),
  .sdo_b     (sdo_b),
  .res_ready (res_ready),
  .frame_one (frame_one),
  .sclk_lvl  (sclk_lvl)
);

// File: tb/dual_readout_port_tb.sv
module dual_readout_port_tb;

  localparam int W          = 18;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         one_wire = 1'b0;
  logic         res_valid = 1'b0;
  logic         res_ready;
  logic [W-1:0] res_a = '0;
  logic [W-1:0] res_b = '0;
  logic         sdo_a, sdo_b, sdo_oe, conv_start;

  int compared = 0;
  int mismatched = 0;
  int frames = 0;
  int starts = 0;

  // bench model
  bit           m_full = 0;
  logic [W-1:0] m_pa = '0, m_pb = '0;
  logic [W-1:0] m_sa = '0, m_sb = '0;
  bit           m_one = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && conv_start) starts++;

  dual_readout_port #(.WORD_W(W), .SYNC_STAGES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .one_wire(one_wire),
    .res_valid(res_valid), .res_ready(res_ready), .res_a(res_a), .res_b(res_b),
    .sdo_a(sdo_a), .sdo_b(sdo_b), .sdo_oe(sdo_oe), .conv_start(conv_start)
  );

  function automatic logic exp_line(input bit one, input bit line_b,
                                    input logic [W-1:0] a, input logic [W-1:0] b,
                                    input int k);
    if (one) begin
      if (line_b)     return 1'b0;
      if (k < W)      return a[W-1-k];
      if (k < 2*W)    return b[2*W-1-k];
      return 1'b0;
    end
    if (k >= W) return 1'b0;
    return line_b ? b[W-1-k] : a[W-1-k];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    res_valid = 1'b1; res_a = a; res_b = b;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    m_full = 1; m_pa = a; m_pb = b;
  endtask

  task automatic begin_frame(input bit one);
    @(negedge clk);
    one_wire = one; cs_n = 1'b0;
    m_one = one;
    if (m_full) begin m_sa = m_pa; m_sb = m_pb; m_full = 0; end
    frames++;
    wait_clk(6);
    chk("R2", "oe in frame", 64'(sdo_oe), 64'd1);
  endtask

  // shifts n bits, sampling each bit before its falling edge, then one more sample
  task automatic shift_bits(input int n, input int toggle_at);
    for (int k = 0; k <= n; k++) begin
      chk(m_one ? "R5" : "R4", $sformatf("line a bit %0d", k),
          64'(sdo_a), 64'(exp_line(m_one, 0, m_sa, m_sb, k)));
      chk(m_one ? "R5" : "R4", $sformatf("line b bit %0d", k),
          64'(sdo_b), 64'(exp_line(m_one, 1, m_sa, m_sb, k)));
      if (k == n) break;
      if (k == toggle_at) one_wire = ~one_wire;   // R10: must not matter
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(6);
    end
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    wait_clk(6);
    chk("R2", "oe after cs high", 64'(sdo_oe), 64'd0);
    chk("R2", "lines low after cs high", 64'({sdo_a, sdo_b}), 64'd0);
    chk("R1", "start pulses vs frames", 64'(starts), 64'(frames));
  endtask

  task automatic full_frame(input bit one, input int toggle_at);
    begin_frame(one);
    shift_bits(one ? 2*W + 1 : W + 1, toggle_at);  // R6 tail included
    end_frame();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog run did not finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);

    // R11 reset state
    chk("R11", "oe", 64'(sdo_oe), 64'd0);
    chk("R11", "lines", 64'({sdo_a, sdo_b}), 64'd0);
    chk("R11", "conv_start", 64'(conv_start), 64'd0);
    chk("R11", "ready", 64'(res_ready), 64'd1);

    // R11/R8: first frame without results sends zeros
    full_frame(1'b0, -1);

    // R4 and R6: dual-line frame with a known pair
    push(18'h2A5C3, 18'h15A3C);
    full_frame(1'b0, -1);

    // R5 and R6: single-line frame
    push(18'h3F00F, 18'h0C3A5);
    full_frame(1'b1, -1);

    // R8: nothing new, repeated words
    full_frame(1'b0, -1);

    // R9: back-pressure while a pair waits
    push(18'h11111, 18'h22222);
    @(negedge clk);
    res_valid = 1'b1; res_a = 18'h3ABCD; res_b = 18'h01234;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9", "ready low while pair waits", 64'(res_ready), 64'd0);
    end
    begin_frame(1'b0);           // takes 11111/22222, then 3ABCD/01234 enters
    res_valid = 1'b0;
    m_full = 1; m_pa = 18'h3ABCD; m_pb = 18'h01234;
    chk("R9", "ready low again after refill", 64'(res_ready), 64'd0);
    shift_bits(W, -1);
    end_frame();
    full_frame(1'b1, -1);        // R3: the held-back pair arrives here

    // R7: abort after a few bits, next frame restarts from the MSB
    push(18'h2B7E1, 18'h15F0A);
    begin_frame(1'b1);
    shift_bits(5, -1);
    end_frame();
    full_frame(1'b0, -1);

    // R10: layout change mid-frame has no effect
    push(18'h0F0F0, 18'h30303);
    full_frame(1'b0, 3);
    push(18'h1E1E1, 18'h2D2D2);
    full_frame(1'b1, 7);

    // R3: pair accepted during a frame belongs to the next one
    begin_frame(1'b0);
    push(18'h35555, 18'h0AAAA);
    shift_bits(W, -1);
    end_frame();
    full_frame(1'b0, -1);

    // random frames
    for (int f = 0; f < 24; f++) begin
      bit one;
      int tot, n, tog;
      one = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) != 0) push(W'($urandom), W'($urandom));
      tot = one ? 2*W : W;
      n   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, tot) : tot + 1;
      tog = ($urandom_range(0, 3) == 0) ? $urandom_range(0, tot) : -1;
      begin_frame(one);
      shift_bits(n, tog);
      end_frame();
    end

    summary();
  end

endmodule